// File: doc/BRIEF.md
# Single-Step Shift Register Unit

This block takes an n-bit value and a 3-bit operation code. Each clock cycle in which the load strobe is high, it stores that value moved one bit position under the selected rule. Logical moves fill the empty end with zero. Circular moves wrap the bit that falls off one end around to the other end. The arithmetic right move copies the sign bit into the top position. The arithmetic left move also raises an overflow flag when the sign would change.

Each output bit comes from a two-way selector. One direction takes the bit from the neighbour above and the other takes it from the neighbour below. The two end positions take a serial input instead, and that input is chosen by the operation. The overflow flag is registered alongside the result, so both reflect the same operation.

Top module: `shift_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `result` is all zeros and `ovf` is 0.
- R2: With `load` high and `op`=000 (logical left), on the next clock `result` equals `din` moved up one position, with bit 0 equal to 0.
- R3: With `load` high and `op`=001 (logical right), on the next clock `result` equals `din` moved down one position, with the top bit equal to 0.
- R4: With `load` high and `op`=010 (circular left), on the next clock `result` equals `din` moved up one position, with bit 0 taking the old top bit of `din`.
- R5: With `load` high and `op`=011 (circular right), on the next clock `result` equals `din` moved down one position, with the top bit taking the old bit 0 of `din`.
- R6: With `load` high and `op`=101 (arithmetic right), on the next clock `result` equals `din` moved down one position, with the top bit equal to the top bit of `din`.
- R7: With `load` high and `op`=100 (arithmetic left), on the next clock `result` equals `din` moved up one position with bit 0 equal to 0. In the same cycle `ovf` is set to 1 if the two most significant bits of `din` differ, and to 0 if they are equal.
- R8: With `load` high and `op` one of 000, 001, 010, 011 or 101, on the next clock `ovf` is 0.
- R9: With `load` high and `op`=110 or 111, `result` and `ovf` keep their previous values.
- R10: With `load` low, `result` and `ovf` keep their previous values whatever `op` and `din` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Applies the operation this cycle |
| op | input | 3 | Operation code (see R2 to R9) |
| din | input | W | Value to be moved |
| result | output | W | Registered moved value |
| ovf | output | 1 | Registered overflow flag of the arithmetic left move |

## Verification
The hardest case to reach is an overflow flag that must survive idle cycles and reserved codes after an arithmetic left move set it, and then drop on the next valid non-arithmetic-left operation. The stimulus first sets the flag with operand patterns whose top two bits are 01 and 10. It then sends idle cycles with changing `din`, then reserved codes, and only after those a clearing operation. A long random phase adds more cases. In it, about a third of the cycles have the strobe low and about a quarter use reserved codes, so holds occur often between flag changes.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;

    typedef enum logic [2:0] {
        OP_LSL = 3'b000,
        OP_LSR = 3'b001,
        OP_ROL = 3'b010,
        OP_ROR = 3'b011,
        OP_ASL = 3'b100,
        OP_ASR = 3'b101,
        OP_RS6 = 3'b110,
        OP_RS7 = 3'b111
    } shift_op_e;

    function automatic logic op_is_valid(input logic [2:0] code);
        return code <= 3'b101;
    endfunction

    function automatic logic op_is_left(input logic [2:0] code);
        return ~code[0];
    endfunction

endpackage

// File: rtl/shift_serial_sel.sv
module shift_serial_sel
    import shift_unit_pkg::*;
(
    input  logic [2:0] op,
    input  logic       top_bit,
    input  logic       bot_bit,
    output logic       fill_low,
    output logic       fill_high
);
    always_comb begin
        fill_low  = 1'b0;
        fill_high = 1'b0;
        case (shift_op_e'(op))
            OP_ROL:  fill_low  = top_bit;
            OP_ROR:  fill_high = bot_bit;
            OP_ASR:  fill_high = top_bit;
            default: begin
                fill_low  = 1'b0;
                fill_high = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/shift_mux_row.sv
module shift_mux_row #(
    parameter int W = 8
) (
    input  logic [W-1:0] src,
    input  logic         go_left,
    input  logic         fill_low,
    input  logic         fill_high,
    output logic [W-1:0] dst
);
    localparam int TOP = W - 1;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            logic from_above;
            logic from_below;
            if (i == TOP) begin : g_top
                assign from_above = fill_high;
            end else begin : g_mid_a
                assign from_above = src[i+1];
            end
            if (i == 0) begin : g_bot
                assign from_below = fill_low;
            end else begin : g_mid_b
                assign from_below = src[i-1];
            end
            assign dst[i] = go_left ? from_below : from_above;
        end
    endgenerate
endmodule

// File: rtl/shift_ovf_detect.sv
module shift_ovf_detect #(
    parameter int W = 8
) (
    input  logic [W-1:0] src,
    output logic         sign_change
);
    localparam int MSB = W - 1;
    localparam int NXT = W - 2;

    assign sign_change = src[MSB] ^ src[NXT];
endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_unit_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [2:0]   op,
    input  logic [W-1:0] din,
    output logic [W-1:0] result,
    output logic         ovf
);
    localparam int MSB = W - 1;

    typedef struct packed {
        logic [W-1:0] val;
        logic         ovf;
    } state_t;

    state_t st_d, st_q;

    logic         fill_low;
    logic         fill_high;
    logic         go_left;
    logic         sign_change;
    logic [W-1:0] moved;

    assign go_left = op_is_left(op);

    shift_serial_sel u_sel (
        .op        (op),
        .top_bit   (din[MSB]),
        .bot_bit   (din[0]),
        .fill_low  (fill_low),
        .fill_high (fill_high)
    );

    shift_mux_row #(.W(W)) u_row (
        .src       (din),
        .go_left   (go_left),
        .fill_low  (fill_low),
        .fill_high (fill_high),
        .dst       (moved)
    );

    shift_ovf_detect #(.W(W)) u_ovf (
        .src         (din),
        .sign_change (sign_change)
    );

    always_comb begin
        st_d = st_q;
        if (load && op_is_valid(op)) begin
            st_d.val = moved;
            st_d.ovf = (shift_op_e'(op) == OP_ASL) ? sign_change : 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result = st_q.val;
    assign ovf    = st_q.ovf;
endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         load,
    input logic [2:0]   op,
    input logic [W-1:0] din,
    input logic [W-1:0] result,
    input logic         ovf
);
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(result) && $stable(ovf))); // R10

    AST_RSV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (load && op[2:1] == 2'b11) |=> ($stable(result) && $stable(ovf))); // R9

    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (load && op != 3'b100 && op[2:1] != 2'b11) |=> !ovf); // R8

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (load && op == 3'b100) |=> (ovf == ($past(din[W-1]) != $past(din[W-2])))); // R7

    AST_LSL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (load && op == 3'b000) |=> (result[0] == 1'b0)); // R2

    AST_LSR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (load && op == 3'b001) |=> (result[W-1] == 1'b0)); // R3

    AST_ROL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (load && op == 3'b010) |=> (result[0] == $past(din[W-1]))); // R4

    AST_ROR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (load && op == 3'b011) |=> (result[W-1] == $past(din[0]))); // R5

    AST_ASR_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (load && op == 3'b101) |=> (result[W-1] == $past(din[W-1]))); // R6

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_ZERO: assert (result == '0 && ovf == 1'b0); // R1
        end
    end
endmodule

bind shift_unit shift_unit_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .op     (op),
    .din    (din),
    .result (result),
    .ovf    (ovf)
);

// File: tb/tb_shift_unit.sv
`timescale 1ns/1ps
module tb_shift_unit;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic [2:0]   op = 3'b000;
    logic [W-1:0] din = '0;
    logic [W-1:0] result;
    logic         ovf;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] m_val = '0;
    logic         m_ovf = 1'b0;

    always #5 clk = ~clk;

    shift_unit #(.W(W)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .op     (op),
        .din    (din),
        .result (result),
        .ovf    (ovf)
    );

    function automatic string tag_of(input logic l, input logic [2:0] c);
        if (!l) return "R10";
        case (c)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R7";
            3'd5: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic model(input logic l, input logic [2:0] c, input logic [W-1:0] v);
        int iv;
        iv = int'(v);
        if (!l || c > 3'd5) return;
        case (c)
            3'd0: m_val = W'((iv * 2) % (1 << W));
            3'd1: m_val = W'(iv / 2);
            3'd2: m_val = W'(((iv * 2) % (1 << W)) + iv / (1 << (W-1)));
            3'd3: m_val = W'(iv / 2 + (iv % 2) * (1 << (W-1)));
            3'd4: m_val = W'((iv * 2) % (1 << W));
            default: m_val = W'(iv / 2 + (iv / (1 << (W-1))) * (1 << (W-1)));
        endcase
        if (c == 3'd4)
            m_ovf = ((iv / (1 << (W-1))) % 2) != ((iv / (1 << (W-2))) % 2);
        else
            m_ovf = 1'b0;
    endtask

    task automatic compare(input string tag);
        checks++;
        if (result !== m_val) begin
            errors++;
            $display("FAIL %s result: actual=%h expected=%h", tag, result, m_val);
        end
        checks++;
        if (ovf !== m_ovf) begin
            errors++;
            $display("FAIL %s ovf: actual=%b expected=%b", tag, ovf, m_ovf);
        end
    endtask

    task automatic step(input logic l, input logic [2:0] c, input logic [W-1:0] v);
        load = l;
        op   = c;
        din  = v;
        @(posedge clk);
        model(l, c, v);
        @(negedge clk);
        compare(tag_of(l, c));
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        // R2 logical left
        step(1'b1, 3'd0, 8'hB5);
        step(1'b1, 3'd0, 8'h80);
        // R3 logical right
        step(1'b1, 3'd1, 8'hB5);
        step(1'b1, 3'd1, 8'h01);
        // R4 circular left
        step(1'b1, 3'd2, 8'h81);
        step(1'b1, 3'd2, 8'h7E);
        // R5 circular right
        step(1'b1, 3'd3, 8'h81);
        step(1'b1, 3'd3, 8'hFE);
        // R6 arithmetic right
        step(1'b1, 3'd5, 8'h90);
        step(1'b1, 3'd5, 8'h70);
        // R7 arithmetic left, both overflow polarities and no overflow
        step(1'b1, 3'd4, 8'h40);
        step(1'b1, 3'd4, 8'hC0);
        step(1'b1, 3'd4, 8'h80);
        // R10 idle with flag set, changing din
        step(1'b0, 3'd0, 8'h12);
        step(1'b0, 3'd3, 8'hFF);
        // R9 reserved codes with flag set
        step(1'b1, 3'd6, 8'h55);
        step(1'b1, 3'd7, 8'hAA);
        // R8 each clearing op after a set flag
        for (int k = 0; k < 6; k++) begin
            if (k == 4) continue;
            step(1'b1, 3'd4, 8'h40);
            step(1'b1, 3'(k), 8'h3C);
        end

        for (int n = 0; n < 400; n++) begin
            logic         rl;
            logic [2:0]   rc;
            logic [W-1:0] rv;
            rl = ($urandom_range(0, 2) != 0);
            rc = ($urandom_range(0, 3) == 0) ? 3'(6 + $urandom_range(0, 1))
                                             : 3'($urandom_range(0, 5));
            rv = W'($urandom);
            step(rl, rc, rv);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule